// File: doc/BRIEF.md
# Mixed-Search Duty-Correction Code Controller

This block is the digital half of a dual-loop duty-cycle correction loop. An external comparator watches the analog correction voltages and gives a single up/down decision. The block turns that decision into an 8-bit code for a current DAC, and also drives the bitwise complement of the code for the differential DAC half. Every code update is paced by an internal divider, so it happens only once per 64 input clocks. This leaves the analog charge pump and the DAC time to settle before the next decision is read.

After a start pulse, the controller runs a successive-approximation search from mid-scale. Each slow tick resolves one trial bit. After seven ticks it changes by itself into a saturating up/down counter that moves one LSB per tick, so the loop stays closed and follows slow drift. When enable is dropped, the block goes idle but keeps its code, so the correction setting survives while the loop is switched off.

Top module: `dcc_mixed_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the code becomes 0x80, `code_n` becomes 0x7F, `locked` and `seq_mode` clear, and the block goes idle.
- R2: A `start` pulse sampled with `enable` high loads the code with 0x80, clears `locked` and `seq_mode`, and restarts the tick divider. A `start` sampled with `enable` low is ignored.
- R3: Once started, the code changes only on slow ticks. A slow tick falls 64 clocks after the start edge and then every 64 clocks.
- R4: In search mode, a tick keeps the current trial bit when `cmp_up` is 1 and clears it when `cmp_up` is 0, then sets the next lower bit as the new trial. The first trial bit is bit 7.
- R5: The seventh search tick (clock 448 after start) resolves bit 1, leaves bit 0 at 1, and raises `seq_mode` and `locked` together. Before that tick, `locked` stays low.
- R6: In counting mode, each tick adds one to the code when `cmp_up` is 1 and subtracts one when it is 0.
- R7: In counting mode, the code holds at 0xFF when asked to go up, and holds at 0x00 when asked to go down.
- R8: With `enable` low, the block goes idle with `locked` and `seq_mode` low and keeps its code unchanged. Raising `enable` again without `start` leaves it idle with the same code.
- R9: `code_n` is always the bitwise complement of `code`.
- R10: A `start` during a search aborts it and begins a new search from 0x80, with the full 448-clock search time counted from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Corrector enable; low holds the code and idles the block |
| start | input | 1 | One-cycle pulse that begins a new search |
| cmp_up | input | 1 | Comparator decision: 1 means the code should rise |
| code | output | 8 | DAC control code |
| code_n | output | 8 | Bitwise complement of the code |
| locked | output | 1 | High once the search has finished |
| seq_mode | output | 1 | High while in counting mode |

## Verification
The bound checker checks these properties on every cycle: the code changes only on a tick or a start, ticks are exactly 64 clocks apart, counting steps are at most one LSB, the code saturates at both rails, the start value is loaded, idling holds the code, and `locked` rises together with the change into counting mode. Some behaviours need complete runs to show them, and only the bench scenarios do this. These are: the bit pattern that the search settles on for a given comparator target, the 448-clock lock time, tracking a target that moves after lock, ignoring start while disabled, keeping the code across a disable and re-enable, and restarting in the middle of a search.

// File: rtl/dcc_ctl_pkg.sv
// Package: shared operating-mode type for the duty-correction code controller.
package dcc_ctl_pkg;
    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_BIN  = 2'd1,
        CTL_SEQ  = 2'd2
    } ctl_mode_e;
endpackage

// File: rtl/dcc_tick_div.sv
// Module: dcc_tick_div
// Free-running divider that produces a one-cycle tick every 2**DIV_BITS clocks.
// Assumes: clear_i restarts the count at zero, so the first tick comes
// 2**DIV_BITS clocks after the clearing edge. No ticks are made while run_i is low.
module dcc_tick_div #(
    parameter int DIV_BITS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam logic [DIV_BITS-1:0] LAST = '1;

    logic [DIV_BITS-1:0] cnt_q;

    // Count clocks while running; reset and clear return the count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // A tick is the last count of each period.
    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
    end
endmodule

// File: rtl/dcc_bin_step.sv
// Module: dcc_bin_step
// One successive-approximation step. It keeps or clears the trial bit marked
// by the one-hot mask, then sets the next lower bit as the new trial.
// Assumes: mask_i is one-hot with a set bit at index 1 or above.
module dcc_bin_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] code_i,
    input  logic [W-1:0] mask_i,
    input  logic         keep_i,
    output logic [W-1:0] code_o,
    output logic [W-1:0] mask_o,
    output logic         last_o
);
    localparam logic [W-1:0] FINAL_MASK = W'(2);

    // Resolve the trial bit and move the trial one place down.
    always_comb begin
        mask_o = mask_i >> 1;
        code_o = (keep_i ? code_i : (code_i & ~mask_i)) | mask_o;
        last_o = (mask_i == FINAL_MASK);
    end
endmodule

// File: rtl/dcc_seq_step.sv
// Module: dcc_seq_step
// One step of the saturating up/down tracking counter.
// Assumes: the caller applies the result only on a slow tick.
module dcc_seq_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] code_i,
    input  logic         up_i,
    output logic [W-1:0] code_o
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] BOT = '0;

    // Move the code by one LSB, or hold it when it is already at the rail.
    always_comb begin
        if (up_i) begin
            code_o = (code_i == TOP) ? code_i : code_i + 1'b1;
        end else begin
            code_o = (code_i == BOT) ? code_i : code_i - 1'b1;
        end
    end
endmodule

// File: rtl/dcc_mixed_ctl.sv
// Module: dcc_mixed_ctl (top)
// Digital loop controller for a duty-cycle corrector. It runs a binary search
// from mid-scale, then changes by itself into a saturating tracking counter.
// Every update is paced at one per 2**DIV_BITS clocks.
// Assumes: cmp_up is stable by the slow tick. start is a pulse taken only
// while enable is high. The code is kept across a disable.
module dcc_mixed_ctl #(
    parameter int W        = 8,
    parameter int DIV_BITS = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         start,
    input  logic         cmp_up,
    output logic [W-1:0] code,
    output logic [W-1:0] code_n,
    output logic         locked,
    output logic         seq_mode
);
    import dcc_ctl_pkg::*;

    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    ctl_mode_e    mode_q;
    logic [W-1:0] code_q;
    logic [W-1:0] mask_q;
    logic         locked_q;
    logic         go;
    logic         tick;
    logic         bin_mode;
    logic         run;
    logic [W-1:0] bin_code;
    logic [W-1:0] bin_mask;
    logic         bin_last;
    logic [W-1:0] seq_code;

    // Decode the control conditions that the divider and the register use.
    always_comb begin
        go       = start && enable;
        run      = enable && (mode_q != CTL_IDLE);
        bin_mode = (mode_q == CTL_BIN);
    end

    dcc_tick_div #(.DIV_BITS(DIV_BITS)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (go),
        .run_i   (run),
        .tick_o  (tick)
    );

    dcc_bin_step #(.W(W)) bin_i (
        .code_i (code_q),
        .mask_i (mask_q),
        .keep_i (cmp_up),
        .code_o (bin_code),
        .mask_o (bin_mask),
        .last_o (bin_last)
    );

    dcc_seq_step #(.W(W)) seq_i (
        .code_i (code_q),
        .up_i   (cmp_up),
        .code_o (seq_code)
    );

    // Mode, code and lock register: start, idle, search step, count step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= CTL_IDLE;
            code_q   <= MID;
            mask_q   <= MID;
            locked_q <= 1'b0;
        end else if (go) begin
            mode_q   <= CTL_BIN;
            code_q   <= MID;
            mask_q   <= MID;
            locked_q <= 1'b0;
        end else if (!enable) begin
            mode_q   <= CTL_IDLE;
            locked_q <= 1'b0;
        end else if (tick) begin
            case (mode_q)
                CTL_BIN: begin
                    code_q <= bin_code;
                    mask_q <= bin_mask;
                    if (bin_last) begin
                        mode_q   <= CTL_SEQ;
                        locked_q <= 1'b1;
                    end
                end
                CTL_SEQ: code_q <= seq_code;
                default: code_q <= code_q;
            endcase
        end
    end

    // Drive the outputs from the registered state.
    always_comb begin
        code     = code_q;
        code_n   = ~code_q;
        locked   = locked_q;
        seq_mode = (mode_q == CTL_SEQ);
    end
endmodule

// File: rtl/dcc_mixed_ctl_chk.sv
// Module: dcc_mixed_ctl_chk
// Property checker bound to dcc_mixed_ctl. It observes the ports plus the
// internal tick and search-mode signals.
module dcc_mixed_ctl_chk #(
    parameter int W        = 8,
    parameter int DIV_BITS = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         start,
    input logic         cmp_up,
    input logic [W-1:0] code,
    input logic         locked,
    input logic         seq_mode,
    input logic         tick,
    input logic         bin_mode
);
    localparam int             PERIOD = 1 << DIV_BITS;
    localparam logic [W-1:0]   MID    = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0]   TOP    = '1;
    localparam logic [W-1:0]   BOT    = '0;

    logic [DIV_BITS:0] gap_q;

    // Count the clocks since the last start or tick, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || (start && enable) || tick) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == (DIV_BITS+1)'(PERIOD - 1)));

    assert_code_only_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(start && enable)) |=> $stable(code));

    assert_start_loads_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && enable) |=> (code == MID) && !locked && !seq_mode);

    assert_lock_with_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_mode) |-> locked && $past(bin_mode));

    assert_seq_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode && tick && enable && !start) |=>
            ($stable(code) || (code == $past(code) + 1'b1) || (code == $past(code) - 1'b1)));

    assert_sat_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode && tick && enable && !start && cmp_up && code == TOP) |=> (code == TOP));

    assert_sat_bot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode && tick && enable && !start && !cmp_up && code == BOT) |=> (code == BOT));

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !seq_mode && !locked && $stable(code));
endmodule

bind dcc_mixed_ctl dcc_mixed_ctl_chk #(.W(W), .DIV_BITS(DIV_BITS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .start    (start),
    .cmp_up   (cmp_up),
    .code     (code),
    .locked   (locked),
    .seq_mode (seq_mode),
    .tick     (tick),
    .bin_mode (bin_mode)
);

// File: tb/dcc_mixed_ctl_tb_top.sv
// Bench for dcc_mixed_ctl. A comparator model answers "code <= target" at
// every falling edge. A target of -1 always asks for down.
module dcc_mixed_ctl_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         start = 1'b0;
    logic         cmp_up = 1'b0;
    logic [W-1:0] code;
    logic [W-1:0] code_n;
    logic         locked;
    logic         seq_mode;

    int checks = 0;
    int errors = 0;
    int tgt = 0;

    // Each entry is {comparator target, expected code at lock}.
    localparam logic [15:0] VEC [6] = '{
        16'h37_37, 16'hA4_A5, 16'h80_81, 16'h01_01, 16'hFE_FF, 16'h7F_7F
    };

    always #5 clk = ~clk;

    dcc_mixed_ctl #(.W(W), .DIV_BITS(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .cmp_up(cmp_up),
        .code(code), .code_n(code_n), .locked(locked), .seq_mode(seq_mode)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic upd();
        cmp_up = (int'(code) <= tgt);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            upd();
        end
    endtask

    // Pulse start; return just after the edge that applied it (E0).
    task automatic do_start();
        @(negedge clk); start = 1'b1; upd();
        @(negedge clk); start = 1'b0; upd();
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 code", code, 8'h80);
        chk("R1 code_n", code_n, 8'h7F);
        chk("R1 locked", {7'd0, locked}, 8'd0);
        chk("R1 seq_mode", {7'd0, seq_mode}, 8'd0);
        enable = 1'b1;

        // R3 R4 R5: walk the search vector table
        for (int v = 0; v < 6; v++) begin
            tgt = int'(VEC[v][15:8]);
            do_start();
            chk("R2 start code", code, 8'h80);
            step(63);
            chk("R3 no update before tick", code, 8'h80);
            step(1);
            chk("R4 first trial", code, (tgt >= 128) ? 8'hC0 : 8'h40);
            step(383);
            chk("R5 not locked early", {7'd0, locked}, 8'd0);
            step(1);
            chk("R5 locked", {7'd0, locked}, 8'd1);
            chk("R5 seq_mode", {7'd0, seq_mode}, 8'd1);
            chk("R5 lock code", code, VEC[v][7:0]);
            chk("R9 complement", code_n, ~VEC[v][7:0]);
        end

        // R6: lock near 0x5A, then the target moves to 0x60
        tgt = 'h5A;
        do_start();
        step(448);
        chk("R5 lock 5A", code, 8'h5B);
        step(64);
        chk("R6 step down", code, 8'h5A);
        tgt = 'h60;
        step(192);
        chk("R6 tracking up", code, 8'h5D);
        chk("R9 complement track", code_n, 8'hA2);

        // R7: saturation at both rails
        tgt = 'hFF;
        do_start();
        step(448);
        chk("R7 lock FF", code, 8'hFF);
        step(128);
        chk("R7 hold FF", code, 8'hFF);
        tgt = -1;
        do_start();
        step(448);
        chk("R7 lock 01", code, 8'h01);
        step(64);
        chk("R7 reach 00", code, 8'h00);
        step(128);
        chk("R7 hold 00", code, 8'h00);

        // R8: disable holds the code; re-enable without start stays idle
        tgt = 'hFF;
        @(negedge clk); enable = 1'b0; upd();
        step(130);
        chk("R8 code held", code, 8'h00);
        chk("R8 seq low", {7'd0, seq_mode}, 8'd0);
        chk("R8 locked low", {7'd0, locked}, 8'd0);
        enable = 1'b1;
        step(130);
        chk("R8 re-enable idle code", code, 8'h00);
        chk("R8 re-enable idle mode", {7'd0, seq_mode}, 8'd0);

        // R2: start while disabled is ignored
        enable = 1'b0;
        do_start();
        step(70);
        chk("R2 ignored start", code, 8'h00);
        chk("R2 ignored start lock", {7'd0, locked}, 8'd0);
        enable = 1'b1;

        // R10: restart during a search
        tgt = 'h20;
        do_start();
        step(100);
        chk("R10 mid-search code", code, 8'h40);
        do_start();
        chk("R10 restart code", code, 8'h80);
        step(447);
        chk("R10 not locked early", {7'd0, locked}, 8'd0);
        step(1);
        chk("R10 lock code", code, 8'h21);

        // R1: synchronous reset in counting mode
        @(negedge clk); rst_n = 1'b0; upd();
        @(negedge clk); rst_n = 1'b1; upd();
        chk("R1 reset code", code, 8'h80);
        chk("R1 reset lock", {7'd0, locked}, 8'd0);
        chk("R1 reset mode", {7'd0, seq_mode}, 8'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule